// File: doc/BRIEF.md
# Per-Queue Interrupt Cause Register with Auto-Clear

This block collects interrupt causes for a network controller with several receive and several transmit queues. Each queue event pulse sets its own bit in a cause register. One further bit follows a level input that is high while any cause in the separate legacy cause register is active. Software reads and writes the block through a simple 32-bit register port. The port offers three word addresses: the cause register, an auto-clear enable register and a request enable register.

In message mode each cause bit belongs to one interrupt vector. A bit that is set and enabled raises a request on its vector, and the request stays up until the matching acknowledge arrives. If the bit's auto-clear enable is set, the acknowledge also clears the bit. In legacy mode no requests are raised and software clears bits by writing ones. In both modes a read of the cause register clears every bit. In message mode the block also drives a mask covering the queue positions of the legacy cause register, so that the same queue event is not signalled on two paths.

Top module: `queue_irq_cause`

## Requirements
- R1: After reset the cause, auto-clear and enable registers read 0, no request is raised, and the legacy mask is 0.
- R2: A pulse on receive queue q sets cause bit q (bits 0 to 3). A pulse on transmit queue q sets bit 8+q (bits 8 to 11). Bit 31 is set on every cycle that the legacy-active input is high. All other bits read 0. The cause register is word address 0.
- R3: A read of address 0 returns the current cause value, and all cause bits are clear from the next cycle.
- R4: In legacy mode (msgMode=0), a write to address 0 clears the cause bits written as 1 and leaves the others unchanged. In message mode (msgMode=1), a write to address 0 has no effect.
- R5: In message mode, a cause bit that is set and enabled drives msgReq[v] high in the same cycle as the bit. The request stays high until acknowledged. Vector order is: v=0..3 for receive queues 0..3, v=4..7 for transmit queues 0..3, and v=8 for the legacy bit.
- R6: When msgReq[v] and msgAck[v] are both high and the bit's auto-clear enable is set, the cause bit clears at that edge and the request drops.
- R7: When the acknowledge arrives and the bit's auto-clear enable is clear, the cause bit stays set. The request drops and is not raised again until the bit has been cleared and set again.
- R8: A bit whose enable is 0 still latches but raises no request. In legacy mode no request is raised at all.
- R9: A cause event in the same cycle as any clear (read, write-1-to-clear or auto-clear acknowledge) leaves the bit set. After an auto-clear acknowledge, that new event raises a new request.
- R10: legacyQueueMask is 32'h0000_0F0F in message mode and 0 in legacy mode.
- R11: Address 1 (auto-clear) and address 2 (enable) are read/write, with their bits at the same positions as the cause bits. Unused bits and address 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 4 | Word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid while regRdEn is high |
| msgMode | input | 1 | 1 = message-signalled mode, 0 = legacy mode |
| rxEvt | input | 4 | Receive queue event pulses |
| txEvt | input | 4 | Transmit queue event pulses |
| legacyActive | input | 1 | High while any legacy cause is active |
| msgReq | output | 9 | Request per vector |
| msgAck | input | 9 | Acknowledge per vector |
| legacyQueueMask | output | 32 | Mask for the queue bits of the legacy cause register |

## Verification
The cause and enable state shows directly on the request outputs in the same cycle, so a wrongly set or lost bit appears on msgReq or in a readback of address 0 within one cycle. A stuck sent flag shows up in two ways. Either a request never rises again after a clear-and-set, or a request rises again right after a non-clearing acknowledge. Both are visible one cycle after the acknowledge. A clear that wins over a same-cycle event shows as a zero on the next read of the cause register.

// File: rtl/qirq_pkg.sv
package qirq_pkg;
  typedef enum logic [1:0] {
    SEL_CAUSE   = 2'd0,
    SEL_AUTOCLR = 2'd1,
    SEL_ENABLE  = 2'd2,
    SEL_NONE    = 2'd3
  } regSel_e;

  typedef struct packed {
    logic causeRd;    // read of cause: clear all
    logic causeW1c;   // write-1-to-clear, legacy mode only
    logic autoClrWr;  // load auto-clear enables
    logic enableWr;   // load request enables
  } strobes_t;
endpackage

// File: rtl/qirq_ctrl.sv
module qirq_ctrl
  import qirq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              msgMode,
  output strobes_t          strb,
  output regSel_e           rdSel
);
  regSel_e addrSel;

  always_comb begin
    if (regAddr == ADDR_W'(0))      addrSel = SEL_CAUSE;
    else if (regAddr == ADDR_W'(1)) addrSel = SEL_AUTOCLR;
    else if (regAddr == ADDR_W'(2)) addrSel = SEL_ENABLE;
    else                            addrSel = SEL_NONE;
  end

  always_comb begin
    strb.causeRd   = regRdEn && (addrSel == SEL_CAUSE);
    strb.causeW1c  = regWrEn && (addrSel == SEL_CAUSE) && !msgMode;
    strb.autoClrWr = regWrEn && (addrSel == SEL_AUTOCLR);
    strb.enableWr  = regWrEn && (addrSel == SEL_ENABLE);
    rdSel          = regRdEn ? addrSel : SEL_NONE;
  end
endmodule

// File: rtl/qirq_dp.sv
module qirq_dp
  import qirq_pkg::*;
#(
  parameter int NUM_RXQ  = 4,
  parameter int NUM_TXQ  = 4,
  parameter int TXQ_BASE = 8,
  parameter int LEG_BIT  = 31,
  parameter int DATA_W   = 32,
  localparam int NUM_VEC = NUM_RXQ + NUM_TXQ + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  regSel_e            rdSel,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic               msgMode,
  input  logic [NUM_RXQ-1:0] rxEvt,
  input  logic [NUM_TXQ-1:0] txEvt,
  input  logic               legacyActive,
  input  logic [NUM_VEC-1:0] msgAck,
  output logic [DATA_W-1:0]  regRdData,
  output logic [NUM_VEC-1:0] msgReq,
  output logic [DATA_W-1:0]  legacyQueueMask
);
  function automatic int posOf(input int v);
    if (v < NUM_RXQ)                return v;
    else if (v < NUM_RXQ + NUM_TXQ) return TXQ_BASE + v - NUM_RXQ;
    else                            return LEG_BIT;
  endfunction

  logic [NUM_VEC-1:0] causeQ, autoClrQ, enableQ, sentQ;
  logic [NUM_VEC-1:0] evtVec, wrVec, clrVec, keepVec, causeNext, newSet, ackTake, sentNext;
  logic [DATA_W-1:0]  causeWord, autoClrWord, enableWord;

  assign evtVec = {legacyActive, txEvt, rxEvt};

  always_comb begin
    wrVec           = '0;
    causeWord       = '0;
    autoClrWord     = '0;
    enableWord      = '0;
    legacyQueueMask = '0;
    for (int v = 0; v < NUM_VEC; v++) begin
      wrVec[v]              = regWrData[posOf(v)];
      causeWord[posOf(v)]   = causeQ[v];
      autoClrWord[posOf(v)] = autoClrQ[v];
      enableWord[posOf(v)]  = enableQ[v];
      if (v < NUM_VEC - 1) legacyQueueMask[posOf(v)] = msgMode;
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_CAUSE:   regRdData = causeWord;
      SEL_AUTOCLR: regRdData = autoClrWord;
      SEL_ENABLE:  regRdData = enableWord;
      default:     regRdData = '0;
    endcase
  end

  // Request: set, enabled, not yet acknowledged, message mode only
  assign msgReq  = {NUM_VEC{msgMode}} & causeQ & enableQ & ~sentQ;
  assign ackTake = msgReq & msgAck;

  // Merge the three clear routes; a same-cycle event overrides them
  assign clrVec    = ({NUM_VEC{strb.causeRd}})
                   | ({NUM_VEC{strb.causeW1c}} & wrVec)
                   | (ackTake & autoClrQ);
  assign keepVec   = causeQ & ~clrVec;
  assign causeNext = keepVec | evtVec;
  assign newSet    = evtVec & ~keepVec;
  assign sentNext  = (sentQ | ackTake) & causeNext & ~newSet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeQ   <= '0;
      autoClrQ <= '0;
      enableQ  <= '0;
      sentQ    <= '0;
    end else begin
      causeQ <= causeNext;
      sentQ  <= sentNext;
      if (strb.autoClrWr) autoClrQ <= wrVec;
      if (strb.enableWr)  enableQ  <= wrVec;
    end
  end
endmodule

// File: rtl/queue_irq_cause.sv
module queue_irq_cause
  import qirq_pkg::*;
#(
  parameter int NUM_RXQ  = 4,
  parameter int NUM_TXQ  = 4,
  parameter int TXQ_BASE = 8,
  parameter int LEG_BIT  = 31,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  localparam int NUM_VEC = NUM_RXQ + NUM_TXQ + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               msgMode,
  input  logic [NUM_RXQ-1:0] rxEvt,
  input  logic [NUM_TXQ-1:0] txEvt,
  input  logic               legacyActive,
  output logic [NUM_VEC-1:0] msgReq,
  input  logic [NUM_VEC-1:0] msgAck,
  output logic [DATA_W-1:0]  legacyQueueMask
);
  strobes_t strb;
  regSel_e  rdSel;

  qirq_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .msgMode (msgMode),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  qirq_dp #(
    .NUM_RXQ(NUM_RXQ), .NUM_TXQ(NUM_TXQ), .TXQ_BASE(TXQ_BASE),
    .LEG_BIT(LEG_BIT), .DATA_W(DATA_W)
  ) i_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strb            (strb),
    .rdSel           (rdSel),
    .regWrData       (regWrData),
    .msgMode         (msgMode),
    .rxEvt           (rxEvt),
    .txEvt           (txEvt),
    .legacyActive    (legacyActive),
    .msgAck          (msgAck),
    .regRdData       (regRdData),
    .msgReq          (msgReq),
    .legacyQueueMask (legacyQueueMask)
  );
endmodule

// File: rtl/qirq_checker.sv
module qirq_checker #(
  parameter int NUM_RXQ  = 4,
  parameter int NUM_TXQ  = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  localparam int NUM_VEC = NUM_RXQ + NUM_TXQ + 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               msgMode,
  input logic               regRdEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [NUM_RXQ-1:0] rxEvt,
  input logic [NUM_TXQ-1:0] txEvt,
  input logic               legacyActive,
  input logic [NUM_VEC-1:0] msgReq,
  input logic [NUM_VEC-1:0] msgAck,
  input logic [DATA_W-1:0]  legacyQueueMask,
  input logic [NUM_VEC-1:0] causeQ,
  input logic [NUM_VEC-1:0] autoClrQ
);
  logic [NUM_VEC-1:0] evtVec;
  assign evtVec = {legacyActive, txEvt, rxEvt};

  AST_NO_REQ_LEGACY: assert property (@(posedge clk) disable iff (!rstN)
    !msgMode |-> (msgReq == '0)); // R8

  AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (legacyQueueMask != '0) |-> msgMode); // R10

  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'(0) && evtVec == '0) |=> (causeQ == '0)); // R3

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    AST_ACK_AUTOCLR: assert property (@(posedge clk) disable iff (!rstN)
      (msgReq[v] && msgAck[v] && autoClrQ[v] && !evtVec[v]) |=> !causeQ[v]); // R6

    AST_ACK_HOLDOFF: assert property (@(posedge clk) disable iff (!rstN)
      (msgReq[v] && msgAck[v] && !autoClrQ[v] && !evtVec[v]) |=> !msgReq[v]); // R7

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rstN)
      evtVec[v] |=> causeQ[v]); // R9
  end
endmodule

bind queue_irq_cause qirq_checker #(
  .NUM_RXQ(NUM_RXQ), .NUM_TXQ(NUM_TXQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk             (clk),
  .rstN            (rstN),
  .msgMode         (msgMode),
  .regRdEn         (regRdEn),
  .regAddr         (regAddr),
  .rxEvt           (rxEvt),
  .txEvt           (txEvt),
  .legacyActive    (legacyActive),
  .msgReq          (msgReq),
  .msgAck          (msgAck),
  .legacyQueueMask (legacyQueueMask),
  .causeQ          (i_dp.causeQ),
  .autoClrQ        (i_dp.autoClrQ)
);

// File: tb/test_queue_irq_cause.sv
module test_queue_irq_cause;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        msgMode = 1'b0;
  logic [3:0]  rxEvt = '0, txEvt = '0;
  logic        legacyActive = 1'b0;
  logic [8:0]  msgReq;
  logic [8:0]  msgAck = '0;
  logic [31:0] legacyQueueMask;

  int nTests = 0, nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  queue_irq_cause i_queue_irq_cause (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .msgMode(msgMode), .rxEvt(rxEvt), .txEvt(txEvt),
    .legacyActive(legacyActive), .msgReq(msgReq), .msgAck(msgAck),
    .legacyQueueMask(legacyQueueMask)
  );

  typedef struct packed {
    logic [3:0]  rx;
    logic [3:0]  tx;
    logic        leg;
    logic        mode;
    logic [31:0] en;
    logic [31:0] expCause;
    logic [8:0]  expReq;
    logic [31:0] expMask;
  } row_t;

  localparam row_t ROWS [5] = '{
    '{4'b0001, 4'b0000, 1'b0, 1'b1, 32'h8000_0F0F, 32'h0000_0001, 9'h001, 32'h0000_0F0F},
    '{4'b1010, 4'b0101, 1'b0, 1'b1, 32'h0000_0F0F, 32'h0000_050A, 9'h05A, 32'h0000_0F0F},
    '{4'b0000, 4'b1000, 1'b1, 1'b0, 32'h8000_0F0F, 32'h8000_0800, 9'h000, 32'h0000_0000},
    '{4'b1111, 4'b1111, 1'b1, 1'b1, 32'h0000_000F, 32'h8000_0F0F, 9'h00F, 32'h0000_0F0F},
    '{4'b0100, 4'b0010, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0204, 9'h000, 32'h0000_0F0F}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [31:0] d);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    step();
    regRdEn = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] rx, input logic [3:0] tx);
    rxEvt = rx; txEvt = tx;
    step();
    rxEvt = '0; txEvt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) step();
    // R1: reset state
    check("R1 req in reset", 32'(msgReq), 32'h0);
    rstN = 1'b1;
    step();
    readReg(4'd0, rd); check("R1 cause", rd, 32'h0);
    readReg(4'd1, rd); check("R1 autoclr", rd, 32'h0);
    readReg(4'd2, rd); check("R1 enable", rd, 32'h0);
    check("R1 mask", legacyQueueMask, 32'h0);

    // R11: register map
    writeReg(4'd1, 32'hFFFF_FFFF);
    readReg(4'd1, rd); check("R11 autoclr map", rd, 32'h8000_0F0F);
    writeReg(4'd2, 32'h1234_5678);
    readReg(4'd2, rd); check("R11 enable map", rd, 32'h0000_0608);
    readReg(4'd3, rd); check("R11 unused addr", rd, 32'h0);
    writeReg(4'd1, 32'h0);

    // Table walk: R2, R5, R8, R10
    foreach (ROWS[i]) begin
      msgMode = ROWS[i].mode;
      writeReg(4'd2, ROWS[i].en);
      legacyActive = ROWS[i].leg;
      pulse(ROWS[i].rx, ROWS[i].tx);
      legacyActive = 1'b0;
      check($sformatf("R5/R8 row %0d req", i), 32'(msgReq), 32'(ROWS[i].expReq));
      check($sformatf("R10 row %0d mask", i), legacyQueueMask, ROWS[i].expMask);
      readReg(4'd0, rd);
      check($sformatf("R2 row %0d cause", i), rd, ROWS[i].expCause);
      readReg(4'd0, rd);
      check($sformatf("R3 row %0d after read", i), rd, 32'h0);
    end

    // R5/R6: hold then auto-clear on ack
    msgMode = 1'b1;
    writeReg(4'd2, 32'h8000_0F0F);
    writeReg(4'd1, 32'h0000_0001);
    pulse(4'b0001, 4'b0000);
    check("R5 req raised", 32'(msgReq), 32'h001);
    step(); step();
    check("R5 req held", 32'(msgReq), 32'h001);
    msgAck = 9'h001; step(); msgAck = '0;
    check("R6 req dropped", 32'(msgReq), 32'h0);
    readReg(4'd0, rd); check("R6 bit auto-cleared", rd, 32'h0);

    // R7: ack without auto-clear
    pulse(4'b0000, 4'b0010);
    check("R7 req raised", 32'(msgReq), 32'h020);
    msgAck = 9'h020; step(); msgAck = '0;
    check("R7 req dropped", 32'(msgReq), 32'h0);
    step();
    check("R7 no re-raise", 32'(msgReq), 32'h0);
    readReg(4'd0, rd); check("R7 bit kept", rd, 32'h0000_0200);
    pulse(4'b0000, 4'b0010);
    check("R7 req after re-set", 32'(msgReq), 32'h020);
    readReg(4'd0, rd);

    // R9: event during auto-clear ack
    pulse(4'b0001, 4'b0000);
    msgAck = 9'h001; rxEvt = 4'b0001; step(); msgAck = '0; rxEvt = '0;
    check("R9 req after ack+event", 32'(msgReq), 32'h001);
    readReg(4'd0, rd); check("R9 bit kept on ack", rd, 32'h0000_0001);

    // R9: event during clear-on-read
    pulse(4'b0100, 4'b0000);
    rxEvt = 4'b0100; readReg(4'd0, rd); rxEvt = '0;
    readReg(4'd0, rd); check("R9 bit kept on read", rd, 32'h0000_0004);

    // R4: write-1-to-clear in legacy mode, ignored in message mode
    msgMode = 1'b0;
    check("R8 no req in legacy", 32'(msgReq), 32'h0);
    pulse(4'b1111, 4'b0000);
    writeReg(4'd0, 32'h0000_0005);
    readReg(4'd0, rd); check("R4 w1c legacy", rd, 32'h0000_000A);
    pulse(4'b0010, 4'b0000);
    rxEvt = 4'b0010; writeReg(4'd0, 32'h0000_0002); rxEvt = '0;
    readReg(4'd0, rd); check("R9 bit kept on w1c", rd, 32'h0000_0002);
    msgMode = 1'b1;
    pulse(4'b0011, 4'b0000);
    writeReg(4'd0, 32'h0000_0003);
    readReg(4'd0, rd); check("R4 write ignored in msg mode", rd, 32'h0000_0003);

    // R2: legacy bit follows level
    legacyActive = 1'b1; step();
    readReg(4'd0, rd); check("R2 legacy bit set", rd, 32'h8000_0000);
    legacyActive = 1'b0;
    readReg(4'd0, rd); check("R2 legacy re-set while high", rd, 32'h8000_0000);
    readReg(4'd0, rd); check("R2 legacy cleared", rd, 32'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule